// File: doc/BRIEF.md
# Control Endpoint Transfer Sequencer

This block steers the default control endpoint of a USB device controller through every control transfer. A setup packet comes first. After it there is either an IN data stage, an OUT data stage or no data stage, and the transfer ends with a status handshake. The link layer reports these events to the sequencer:

- setup packet ready
- OUT packet ready
- transmit FIFO full
- setup abort
- stall sent

A separate decoding block looks at each setup packet. It tells the sequencer whether to stall the transfer or to hold the status stage back.

A request side hands the sequencer one buffer at a time, with its length and a flag that asks for a trailing zero-length packet. The sequencer splits the buffer into chunks no larger than `MAXP` and reports completion on the request side. It raises setup acknowledge, data-end and stall strobes, which the link layer turns into handshakes. All outputs are registered, so each one responds in the cycle after the edge that sampled the event.

Top module: `ctl_ep_seq`

## Requirements
- R1: After reset the phase is SETUP (code 0) and no request is pending. Every strobe, `dir_tx`, `tx_count` and `rx_take` are 0.
- R2: `setup_rdy` is acted on only in the SETUP phase and only when `rx_count` equals 8. With any other count, no strobe is raised and the phase stays the same.
- R3: The phase codes are SETUP=0, IN=1, OUT=2, TX-END=3 and STALL=4; an unused code forces `send_stall` and a return to SETUP. A valid setup packet with `setup_len`=0 raises `setup_ack` and `data_end` together and stays in SETUP. A non-zero length with `setup_dir_in`=1 raises `setup_ack`, sets `dir_tx` and enters IN. A non-zero length with `setup_dir_in`=0 raises `setup_ack`, clears `dir_tx` and enters OUT. A valid setup packet also completes (`req_done`) any request still pending.
- R4: In IN, a chunk is loaded only while `fifo_full` is low, and never in the cycle right after a load. The chunk (`tx_count`) is the smaller of `MAXP` and the remaining length. The phase becomes TX-END after a chunk shorter than `MAXP`, or after the last bytes when the zero-length flag is clear. When the flag is set, one extra zero-length chunk follows.
- R5: In TX-END, once `fifo_full` is low, `data_end` and `req_done` pulse together and the phase returns to SETUP.
- R6: In OUT, each packet raises `rx_ack`, and `rx_take` is the smaller of `rx_count` and the remaining length. `overflow` is raised when `rx_count` exceeds the remaining length. The transfer ends with `data_end` and `req_done` when the packet taken is shorter than `MAXP` or fills the buffer.
- R7: An OUT packet that arrives with no pending request raises `rx_ack` and `send_stall` together and enters STALL.
- R8: When the decoder asks for a stall and the transfer has no data stage, `send_stall` and `setup_ack` pulse together. When it asks for a stall and there is a data stage, only `send_stall` pulses. Either way the phase becomes STALL.
- R9: `sent_stall` in any phase raises `stall_clr` and returns the phase to SETUP.
- R10: `setup_abort` returns the phase to SETUP from any phase, including an active data phase.
- R11: A no-data transfer with `hnd_delay` set gives no handshake at setup time. The next `req_valid` then raises `setup_ack` and `data_end` together and is not taken as a pending request.
- R12: A `req_valid` is refused with `req_err` while a request is pending, or in TX-END or STALL. A refused request changes neither the pending transfer nor the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_rdy | input | 1 | Setup packet waiting in the FIFO |
| rx_count | input | CW | Byte count of the received packet |
| setup_dir_in | input | 1 | Direction bit (bit 7 of the request type) of the setup packet |
| setup_len | input | LW | Data-stage length from the setup packet |
| hnd_stall | input | 1 | Decoder asks for a stall of this transfer |
| hnd_delay | input | 1 | Decoder asks to delay the status stage |
| pkt_rdy | input | 1 | OUT data packet waiting in the FIFO |
| fifo_full | input | 1 | Transmit FIFO still holds a packet |
| setup_abort | input | 1 | New setup arrived and aborts the current transfer |
| sent_stall | input | 1 | Link has sent a stall handshake |
| req_valid | input | 1 | Request side supplies a buffer, or continues a delayed status |
| req_len | input | LW | Buffer length of the request |
| req_zero | input | 1 | Request asks for a trailing zero-length packet |
| phase | output | 3 | Current phase code |
| dir_tx | output | 1 | Data stage direction is transmit |
| setup_ack | output | 1 | Setup acknowledge strobe |
| data_end | output | 1 | Data-end / status strobe |
| send_stall | output | 1 | Stall request strobe |
| stall_clr | output | 1 | Write-one-to-clear strobe for the sent-stall flag |
| tx_load | output | 1 | Load a chunk into the transmit FIFO |
| tx_count | output | CW | Byte count of the loaded chunk |
| rx_ack | output | 1 | Received packet is consumed |
| rx_take | output | CW | Bytes taken from the received packet |
| overflow | output | 1 | Received packet exceeded the remaining length |
| req_done | output | 1 | Pending request completed |
| req_err | output | 1 | Request refused |

## Verification
The assertions assume that `sent_stall`, `setup_abort` and `req_valid` never arrive in the same cycle as one another. They also assume the link raises `fifo_full` in the cycle after each `tx_load` and holds it for a few cycles. Finally, they assume a delayed-status continue never coincides with a new setup packet. The stimulus drives one event per cycle, from the falling edge. A small FIFO model in the bench produces `fifo_full` from `tx_load` with that fixed latency.

// File: rtl/ctl_ep_seq.sv
module ctl_ep_seq #(
  parameter int MAXP = 64,
  parameter int LW = 16,
  localparam int CW = $clog2(MAXP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          setup_rdy,
  input  logic [CW-1:0] rx_count,
  input  logic          setup_dir_in,
  input  logic [LW-1:0] setup_len,
  input  logic          hnd_stall,
  input  logic          hnd_delay,
  input  logic          pkt_rdy,
  input  logic          fifo_full,
  input  logic          setup_abort,
  input  logic          sent_stall,
  input  logic          req_valid,
  input  logic [LW-1:0] req_len,
  input  logic          req_zero,
  output logic [2:0]    phase,
  output logic          dir_tx,
  output logic          setup_ack,
  output logic          data_end,
  output logic          send_stall,
  output logic          stall_clr,
  output logic          tx_load,
  output logic [CW-1:0] tx_count,
  output logic          rx_ack,
  output logic [CW-1:0] rx_take,
  output logic          overflow,
  output logic          req_done,
  output logic          req_err
);
  localparam logic [2:0] PH_SETUP = 3'd0, PH_IN = 3'd1, PH_OUT = 3'd2,
                         PH_TXEND = 3'd3, PH_STALL = 3'd4;
  localparam logic [LW-1:0] MAXP_L = LW'(MAXP);

  logic [LW-1:0] rem;
  logic zflag, pend, delayed, tx_hold;

  wire [LW-1:0] in_cnt = (rem < MAXP_L) ? rem : MAXP_L;
  wire [LW-1:0] rx_l   = LW'(rx_count);
  wire          rx_big = rx_l > rem;
  wire [LW-1:0] rx_cnt = rx_big ? rem : rx_l;
  wire          tx_go  = !fifo_full && !tx_hold;
  wire          accept_ph = (phase == PH_SETUP) || (phase == PH_IN) || (phase == PH_OUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_SETUP; dir_tx <= 1'b0; setup_ack <= 1'b0; data_end <= 1'b0;
      send_stall <= 1'b0; stall_clr <= 1'b0; tx_load <= 1'b0; tx_count <= '0;
      rx_ack <= 1'b0; rx_take <= '0; overflow <= 1'b0; req_done <= 1'b0;
      req_err <= 1'b0; rem <= '0; zflag <= 1'b0; pend <= 1'b0;
      delayed <= 1'b0; tx_hold <= 1'b0;
    end else begin
      setup_ack <= 1'b0; data_end <= 1'b0; send_stall <= 1'b0; stall_clr <= 1'b0;
      tx_load <= 1'b0; rx_ack <= 1'b0; overflow <= 1'b0; req_done <= 1'b0;
      req_err <= 1'b0; tx_hold <= 1'b0;
      if (sent_stall) begin
        stall_clr <= 1'b1; phase <= PH_SETUP; delayed <= 1'b0;
      end else if (setup_abort) begin
        phase <= PH_SETUP; delayed <= 1'b0;
      end else begin
        case (phase)
          PH_SETUP: if (setup_rdy && rx_count == CW'(8)) begin
            if (pend) begin req_done <= 1'b1; pend <= 1'b0; end
            delayed <= 1'b0;
            if (hnd_stall) begin
              send_stall <= 1'b1;
              setup_ack <= (setup_len == '0);
              phase <= PH_STALL;
            end else if (setup_len == '0) begin
              if (hnd_delay) delayed <= 1'b1;
              else begin setup_ack <= 1'b1; data_end <= 1'b1; end
            end else begin
              setup_ack <= 1'b1;
              dir_tx <= setup_dir_in;
              phase <= setup_dir_in ? PH_IN : PH_OUT;
            end
          end
          PH_IN: if (pend && tx_go) begin
            tx_load <= 1'b1;
            tx_count <= CW'(in_cnt);
            rem <= rem - in_cnt;
            tx_hold <= 1'b1;
            if (in_cnt < MAXP_L || (in_cnt == rem && !zflag)) phase <= PH_TXEND;
          end
          PH_OUT: if (pkt_rdy) begin
            rx_ack <= 1'b1;
            if (pend) begin
              rx_take <= CW'(rx_cnt);
              overflow <= rx_big;
              rem <= rem - rx_cnt;
              if (rx_cnt < MAXP_L || rx_cnt == rem) begin
                data_end <= 1'b1; req_done <= 1'b1; pend <= 1'b0; phase <= PH_SETUP;
              end
            end else begin
              send_stall <= 1'b1; phase <= PH_STALL;
            end
          end
          PH_TXEND: if (tx_go) begin
            data_end <= 1'b1; req_done <= 1'b1; pend <= 1'b0; phase <= PH_SETUP;
          end
          PH_STALL: ;
          default: begin send_stall <= 1'b1; phase <= PH_SETUP; end
        endcase
      end
      if (req_valid) begin
        if (delayed) begin
          delayed <= 1'b0; setup_ack <= 1'b1; data_end <= 1'b1;
        end else if (pend || !accept_ph) begin
          req_err <= 1'b1;
        end else begin
          pend <= 1'b1; rem <= req_len; zflag <= req_zero;
        end
      end
    end
  end
endmodule

// File: rtl/ctl_ep_seq_chk.sv
module ctl_ep_seq_chk #(
  parameter int MAXP = 64,
  localparam int CW = $clog2(MAXP + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          setup_abort,
  input logic          sent_stall,
  input logic [2:0]    phase,
  input logic          send_stall,
  input logic          data_end,
  input logic          stall_clr,
  input logic          tx_load,
  input logic [CW-1:0] tx_count,
  input logic          rx_ack,
  input logic [CW-1:0] rx_take
);
  // R3
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) phase <= 3'd4);
  // R9
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sent_stall |=> (stall_clr && phase == 3'd0));
  // R10
  abort_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_abort && !sent_stall) |=> (phase == 3'd0 && !tx_load && !rx_ack));
  // R8
  stall_vs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(send_stall && data_end));
  // R4
  chunk_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> tx_count <= CW'(MAXP));
  // R4
  load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);
  // R6
  take_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && !send_stall) |-> rx_take <= CW'(MAXP));
endmodule

bind ctl_ep_seq ctl_ep_seq_chk #(.MAXP(MAXP)) chk (.*);

// File: tb/ctl_ep_seq_test.sv
module ctl_ep_seq_test;
  localparam int MAXP = 64, LW = 16, CW = $clog2(MAXP + 1);

  logic clk = 0, rst_n = 0;
  logic setup_rdy = 0, setup_dir_in = 0, hnd_stall = 0, hnd_delay = 0;
  logic [CW-1:0] rx_count = '0;
  logic [LW-1:0] setup_len = '0, req_len = '0;
  logic pkt_rdy = 0, fifo_full, setup_abort = 0, sent_stall = 0, req_valid = 0, req_zero = 0;
  logic [2:0] phase;
  logic dir_tx, setup_ack, data_end, send_stall, stall_clr, tx_load, rx_ack, overflow, req_done, req_err;
  logic [CW-1:0] tx_count, rx_take;
  int nchk = 0, nerr = 0;
  int ffc = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (tx_load) ffc <= 3;
    else if (ffc != 0) ffc <= ffc - 1;
  end
  assign fifo_full = (ffc != 0);

  ctl_ep_seq #(.MAXP(MAXP), .LW(LW)) uut (.*);

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic do_setup(int cnt, bit dir, int len, bit stl, bit dly);
    setup_rdy = 1; rx_count = CW'(cnt); setup_dir_in = dir; setup_len = LW'(len);
    hnd_stall = stl; hnd_delay = dly;
    tick;
    setup_rdy = 0; hnd_stall = 0; hnd_delay = 0;
  endtask

  task automatic do_req(int len, bit z);
    req_valid = 1; req_len = LW'(len); req_zero = z;
    tick;
    req_valid = 0;
  endtask

  task automatic do_pkt(int cnt);
    pkt_rdy = 1; rx_count = CW'(cnt);
    tick;
    pkt_rdy = 0;
  endtask

  task automatic pulse_abort;
    setup_abort = 1; tick; setup_abort = 0; tick;
  endtask

  task automatic pulse_sent;
    sent_stall = 1; tick; sent_stall = 0;
  endtask

  task automatic wait_load(int exp, string tag);
    bit seen = 0;
    for (int i = 0; i < 30; i++) begin
      tick;
      if (tx_load) begin seen = 1; break; end
    end
    check({tag, " load seen"}, seen, 1);
    check({tag, " chunk"}, tx_count, exp);
  endtask

  task automatic wait_end(string tag);
    bit seen = 0;
    for (int i = 0; i < 30; i++) begin
      tick;
      if (data_end) begin seen = 1; break; end
    end
    check({tag, " data_end"}, seen, 1);
    check({tag, " req_done"}, req_done, 1);
    check({tag, " phase"}, phase, 0);
  endtask

  // {cnt[7], dir, len[16], ack, dend, phase[3], dirtx}
  localparam logic [29:0] VEC [6] = '{
    {7'd8, 1'b0, 16'd0,  1'b1, 1'b1, 3'd0, 1'b0},
    {7'd8, 1'b1, 16'd18, 1'b1, 1'b0, 3'd1, 1'b1},
    {7'd8, 1'b0, 16'd5,  1'b1, 1'b0, 3'd2, 1'b0},
    {7'd7, 1'b1, 16'd18, 1'b0, 1'b0, 3'd0, 1'b0},
    {7'd9, 1'b0, 16'd0,  1'b0, 1'b0, 3'd0, 1'b0},
    {7'd8, 1'b1, 16'd0,  1'b1, 1'b1, 3'd0, 1'b0}
  };

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    #4000000;
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary;
    $finish;
  end

  initial begin
    tick; tick; rst_n = 1; tick;
    // R1 reset state
    check("R1 phase", phase, 0);
    check("R1 strobes", {setup_ack, data_end, send_stall, stall_clr, tx_load, rx_ack, req_done, req_err}, 0);
    check("R1 dir_tx", dir_tx, 0);
    check("R1 counts", {tx_count, rx_take}, 0);

    // R2 R3 setup decode table
    foreach (VEC[i]) begin
      do_setup(int'(VEC[i][29:23]), VEC[i][22], int'(VEC[i][21:6]), 0, 0);
      check($sformatf("R3 R2 vec%0d ack", i), setup_ack, VEC[i][5]);
      check($sformatf("R3 R2 vec%0d dend", i), data_end, VEC[i][4]);
      check($sformatf("R3 R2 vec%0d phase", i), phase, int'(VEC[i][3:1]));
      check($sformatf("R3 R2 vec%0d dir_tx", i), dir_tx, VEC[i][0]);
      pulse_abort;
    end

    // R4 R5 IN 150 bytes: 64,64,22
    do_setup(8, 1, 150, 0, 0);
    do_req(150, 0);
    wait_load(64, "R4 in150 c1");
    wait_load(64, "R4 in150 c2");
    wait_load(22, "R4 in150 c3");
    check("R4 in150 txend", phase, 3);
    wait_end("R5 in150");

    // R4 exact multiple with zero flag: 64,64,0
    do_setup(8, 1, 128, 0, 0);
    do_req(128, 1);
    wait_load(64, "R4 zlp c1");
    wait_load(64, "R4 zlp c2");
    check("R4 zlp still in", phase, 1);
    wait_load(0, "R4 zlp c3");
    wait_end("R5 zlp");

    // R4 exact multiple, no zero flag
    do_setup(8, 1, 128, 0, 0);
    do_req(128, 0);
    wait_load(64, "R4 exact c1");
    wait_load(64, "R4 exact c2");
    check("R4 exact txend", phase, 3);
    wait_end("R5 exact");

    // R6 R12 OUT with overflow and busy
    do_setup(8, 0, 100, 0, 0);
    do_req(100, 0);
    do_pkt(64);
    check("R6 out take1", rx_take, 64);
    check("R6 out no end", data_end, 0);
    do_req(20, 0);
    check("R12 busy err", req_err, 1);
    check("R12 busy phase", phase, 2);
    do_pkt(64);
    check("R6 out take2 truncated", rx_take, 36);
    check("R6 out overflow", overflow, 1);
    check("R6 out end", data_end, 1);
    check("R6 out done", req_done, 1);
    check("R6 out phase", phase, 0);

    // R6 short packet ends
    do_setup(8, 0, 100, 0, 0);
    do_req(100, 0);
    do_pkt(10);
    check("R6 short take", rx_take, 10);
    check("R6 short end", data_end, 1);
    check("R6 short ovf", overflow, 0);

    // R6 full buffer ends
    do_setup(8, 0, 64, 0, 0);
    do_req(64, 0);
    do_pkt(64);
    check("R6 full end", data_end, 1);
    check("R6 full done", req_done, 1);

    // R7 OUT without request
    do_setup(8, 0, 8, 0, 0);
    do_pkt(8);
    check("R7 rx_ack", rx_ack, 1);
    check("R7 stall", send_stall, 1);
    check("R7 phase", phase, 4);
    do_req(8, 0);
    check("R12 stall phase err", req_err, 1);
    pulse_sent;
    check("R9 clr", stall_clr, 1);
    check("R9 phase", phase, 0);

    // R8 stall without data stage
    do_setup(8, 0, 0, 1, 0);
    check("R8 nodata stall", send_stall, 1);
    check("R8 nodata ack", setup_ack, 1);
    check("R8 nodata phase", phase, 4);
    pulse_sent;
    // R8 stall with data stage
    do_setup(8, 1, 4, 1, 0);
    check("R8 data stall", send_stall, 1);
    check("R8 data no ack", setup_ack, 0);
    pulse_sent;
    check("R9 phase2", phase, 0);

    // R10 abort mid IN
    do_setup(8, 1, 150, 0, 0);
    do_req(150, 0);
    wait_load(64, "R10 pre");
    setup_abort = 1; tick; setup_abort = 0;
    check("R10 phase", phase, 0);
    tick; tick; tick; tick; tick; tick;
    check("R10 no load", tx_load, 0);

    // R11 delayed status; setup also flushes the leftover request (R3)
    do_setup(8, 0, 0, 0, 1);
    check("R3 leftover done", req_done, 1);
    check("R11 no ack", setup_ack, 0);
    check("R11 no dend", data_end, 0);
    tick; tick;
    do_req(0, 0);
    check("R11 cont ack", setup_ack, 1);
    check("R11 cont dend", data_end, 1);
    check("R11 cont no err", req_err, 0);
    do_req(0, 0);
    check("R11 not pending", req_err, 0);
    do_setup(8, 0, 0, 0, 0);
    check("R3 flush done", req_done, 1);

    tick;
    summary;
    $finish;
  end
endmodule